// File: doc/BRIEF.md
# Script Branch Condition Evaluator

This block decides the outcome of a transfer-control instruction in a bus-controller script engine. A decoded instruction arrives with a one-cycle valid strobe. The block evaluates the instruction's condition and returns two results: whether the branch is taken, and the address the engine fetches next. The condition can test the ALU carry. It can instead compare the current bus phase, a data byte, or both against values carried in the instruction. A polarity bit then selects whether a match or a mismatch takes the branch.

The bus phase is not sampled continuously. A separate capture stage stores the three phase lines, message, control/data and input/output, at the moment the target raises its request strobe. The compare uses this stored value. The branch target is either the instruction's 32-bit target word, used as an absolute address, or a signed 24-bit offset. The offset is added to the instruction pointer, which already points past the current instruction. Return and interrupt instructions always use the absolute form.

A taken branch whose instruction carries the fly-interrupt bit sets a sticky status flag. Execution does not stop. Software clears the flag with a one-cycle clear pulse.

Top module: `script_branch_eval`

## Requirements
- R1: While reset is held and in the first cycle after it, res_valid, branch_taken, next_pc and fly_status are all zero. The captured phase resets to 3'b000.
- R2: The captured phase is loaded with {ph_msg, ph_cd, ph_io} on a clock edge where req_strobe is high and was low at the previous edge. At every other edge it holds its value, including while req_strobe stays high and the phase lines change.
- R3: With instr_phase_en set in initiator mode (target_mode low), the phase test matches only when the captured phase equals instr_phase. Encoding {msg,cd,io}: 000 data-out, 001 data-in, 010 command, 011 status, 100 and 101 reserved out/in, 110 message-out, 111 message-in.
- R4: With instr_data_en set, the data test matches only when bus_data equals instr_data. When both the phase test and the data test are enabled, the condition is the AND of the two matches.
- R5: With instr_carry_test set, the condition is alu_carry, and the phase and data enables are ignored.
- R6: When at least one test is active, instr_if_true = 1 takes the branch on a match and instr_if_true = 0 takes it on a mismatch. When no test is active, the branch is always taken, whatever the polarity bit says.
- R7: With target_mode high, instr_phase_en is ignored. The condition is formed as if the phase test were disabled.
- R8: res_valid is high in exactly the cycle after a cycle with instr_valid high, and low otherwise. When branch_taken is low in that cycle, next_pc equals the next_ptr presented with the instruction.
- R9: For a taken branch with instr_kind 00 (jump) or 01 (call) and instr_rel set, next_pc = next_ptr + sign-extended instr_target[23:0], modulo 2^32. Without instr_rel, next_pc = instr_target.
- R10: For instr_kind 10 (return) or 11 (interrupt), instr_rel is ignored, and a taken branch gives next_pc = instr_target.
- R11: fly_status is set in the cycle after a taken instruction with instr_fly_irq set. It stays set until a cycle in which fly_clear is high. A clear in the same cycle as a set loses: the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_strobe | input | 1 | Target request strobe; its rising edge captures the phase |
| ph_msg | input | 1 | Message phase line |
| ph_cd | input | 1 | Control/data phase line |
| ph_io | input | 1 | Input/output phase line |
| target_mode | input | 1 | High when the engine acts as target; disables the phase test |
| instr_valid | input | 1 | One-cycle strobe for a decoded transfer-control instruction |
| instr_kind | input | 2 | 00 jump, 01 call, 10 return, 11 interrupt |
| instr_carry_test | input | 1 | Use the ALU carry as the condition |
| instr_phase_en | input | 1 | Enable the phase compare |
| instr_data_en | input | 1 | Enable the data compare |
| instr_if_true | input | 1 | Polarity: 1 takes on match, 0 takes on mismatch |
| instr_fly_irq | input | 1 | Raise the fly interrupt when taken |
| instr_rel | input | 1 | Treat target bits 23:0 as a signed offset |
| instr_phase | input | 3 | Expected phase {msg,cd,io} |
| instr_data | input | 8 | Expected data byte |
| instr_target | input | 32 | Absolute target or offset in bits 23:0 |
| bus_data | input | 8 | Data byte under test |
| alu_carry | input | 1 | ALU carry bit |
| next_ptr | input | 32 | Address of the instruction after the current one |
| fly_clear | input | 1 | One-cycle pulse that clears fly_status |
| res_valid | output | 1 | Result strobe |
| branch_taken | output | 1 | Branch decision, valid with res_valid |
| next_pc | output | 32 | Next fetch address, valid with res_valid |
| fly_status | output | 1 | Sticky fly-interrupt flag |

## Verification
The hardest case to reach from the ports is the phase hold. The bench raises req_strobe with one phase on the lines, then changes the lines while the strobe is still high. A following phase compare must match the first phase and not the second. The same path can hide a capture stage that samples on level rather than on edge. The bench therefore keeps the strobe high across a compare that names the later phase, and expects a mismatch. Relative wrap past 2^32 and a clear pulse that meets a set in the same cycle are both driven on purpose. Each gets its own scoreboard entry or status check.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int PTR_W  = 32;
    localparam int OFS_W  = 24;
    localparam int DATA_W = 8;
    localparam int PH_W   = 3;

    typedef enum logic [PH_W-1:0] {
        PH_DATA_OUT = 3'b000,
        PH_DATA_IN  = 3'b001,
        PH_COMMAND  = 3'b010,
        PH_STATUS   = 3'b011,
        PH_RSV_OUT  = 3'b100,
        PH_RSV_IN   = 3'b101,
        PH_MSG_OUT  = 3'b110,
        PH_MSG_IN   = 3'b111
    } bus_phase_e;

    typedef enum logic [1:0] {
        XK_JUMP   = 2'b00,
        XK_CALL   = 2'b01,
        XK_RETURN = 2'b10,
        XK_INTR   = 2'b11
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e              kind;
        logic                    carry_test;
        logic                    phase_en;
        logic                    data_en;
        logic                    if_true;
        logic                    fly_irq;
        logic                    rel;
        bus_phase_e              want_phase;
        logic [DATA_W-1:0]       want_data;
        logic [PTR_W-1:0]        target;
    } xfer_instr_t;

    typedef struct packed {
        logic                    taken;
        logic [PTR_W-1:0]        pc;
    } branch_res_t;

    function automatic logic kind_allows_rel(xfer_kind_e k);
        return (k == XK_JUMP) || (k == XK_CALL);
    endfunction

    function automatic logic [PTR_W-1:0] offset_add(logic [PTR_W-1:0] base,
                                                    logic [OFS_W-1:0] ofs);
        logic [PTR_W-1:0] ext;
        ext = {{(PTR_W-OFS_W){ofs[OFS_W-1]}}, ofs};
        return base + ext;
    endfunction

endpackage

// File: rtl/sbc_phase_capture.sv
module sbc_phase_capture
    import sbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_strobe,
    input  logic [PH_W-1:0]  lines,
    output bus_phase_e       phase_q
);
    logic req_d;
    logic req_rise;

    assign req_rise = req_strobe & ~req_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d   <= 1'b0;
            phase_q <= PH_DATA_OUT;
        end else begin
            req_d <= req_strobe;
            if (req_rise) phase_q <= bus_phase_e'(lines);
        end
    end
endmodule

// File: rtl/sbc_cond_eval.sv
module sbc_cond_eval
    import sbc_pkg::*;
(
    input  xfer_instr_t        instr,
    input  bus_phase_e         cur_phase,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic               alu_carry,
    input  logic               target_mode,
    output logic               taken
);
    logic phase_act;
    logic phase_ok;
    logic data_ok;
    logic any_test;
    logic matched;

    always_comb begin
        phase_act = instr.phase_en & ~target_mode;
        phase_ok  = ~phase_act | (cur_phase == instr.want_phase);
        data_ok   = ~instr.data_en | (bus_data == instr.want_data);
        any_test  = instr.carry_test | phase_act | instr.data_en;
        matched   = instr.carry_test ? alu_carry : (phase_ok & data_ok);
        taken     = ~any_test | (matched == instr.if_true);
    end
endmodule

// File: rtl/sbc_target_sel.sv
module sbc_target_sel
    import sbc_pkg::*;
(
    input  xfer_instr_t       instr,
    input  logic [PTR_W-1:0]  next_ptr,
    input  logic              taken,
    output branch_res_t       res
);
    logic [PTR_W-1:0] dest;

    always_comb begin
        if (instr.rel && kind_allows_rel(instr.kind))
            dest = offset_add(next_ptr, instr.target[OFS_W-1:0]);
        else
            dest = instr.target;
        res.taken = taken;
        res.pc    = taken ? dest : next_ptr;
    end
endmodule

// File: rtl/script_branch_eval.sv
module script_branch_eval
    import sbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_strobe,
    input  logic               ph_msg,
    input  logic               ph_cd,
    input  logic               ph_io,
    input  logic               target_mode,
    input  logic               instr_valid,
    input  logic [1:0]         instr_kind,
    input  logic               instr_carry_test,
    input  logic               instr_phase_en,
    input  logic               instr_data_en,
    input  logic               instr_if_true,
    input  logic               instr_fly_irq,
    input  logic               instr_rel,
    input  logic [PH_W-1:0]    instr_phase,
    input  logic [DATA_W-1:0]  instr_data,
    input  logic [PTR_W-1:0]   instr_target,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic               alu_carry,
    input  logic [PTR_W-1:0]   next_ptr,
    input  logic               fly_clear,
    output logic               res_valid,
    output logic               branch_taken,
    output logic [PTR_W-1:0]   next_pc,
    output logic               fly_status
);
    xfer_instr_t ins;
    bus_phase_e  lat_phase;
    logic        cond_taken;
    branch_res_t res_d;

    always_comb begin
        ins.kind       = xfer_kind_e'(instr_kind);
        ins.carry_test = instr_carry_test;
        ins.phase_en   = instr_phase_en;
        ins.data_en    = instr_data_en;
        ins.if_true    = instr_if_true;
        ins.fly_irq    = instr_fly_irq;
        ins.rel        = instr_rel;
        ins.want_phase = bus_phase_e'(instr_phase);
        ins.want_data  = instr_data;
        ins.target     = instr_target;
    end

    sbc_phase_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .req_strobe (req_strobe),
        .lines      ({ph_msg, ph_cd, ph_io}),
        .phase_q    (lat_phase)
    );

    sbc_cond_eval u_cond (
        .instr       (ins),
        .cur_phase   (lat_phase),
        .bus_data    (bus_data),
        .alu_carry   (alu_carry),
        .target_mode (target_mode),
        .taken       (cond_taken)
    );

    sbc_target_sel u_tgt (
        .instr    (ins),
        .next_ptr (next_ptr),
        .taken    (cond_taken),
        .res      (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid    <= 1'b0;
            branch_taken <= 1'b0;
            next_pc      <= '0;
            fly_status   <= 1'b0;
        end else begin
            res_valid <= instr_valid;
            if (instr_valid) begin
                branch_taken <= res_d.taken;
                next_pc      <= res_d.pc;
            end else begin
                branch_taken <= 1'b0;
            end
            if (instr_valid && res_d.taken && instr_fly_irq)
                fly_status <= 1'b1;
            else if (fly_clear)
                fly_status <= 1'b0;
        end
    end
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker
    import sbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_strobe,
    input  logic [PH_W-1:0]   lat_phase,
    input  logic              instr_valid,
    input  logic              instr_fly_irq,
    input  logic [PTR_W-1:0]  next_ptr,
    input  logic              fly_clear,
    input  logic              res_valid,
    input  logic              branch_taken,
    input  logic [PTR_W-1:0]  next_pc,
    input  logic              fly_status
);
    logic req_seen;

    always_ff @(posedge clk) begin
        if (rst) req_seen <= 1'b0;
        else     req_seen <= req_strobe;
    end

    // R2: without a rising strobe the captured phase does not move
    a_r2_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !(req_strobe && !req_seen) |=> $stable(lat_phase));

    // R8: a result follows every instruction strobe
    a_r8_result_pulse: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> res_valid);

    // R8: no result without an instruction strobe
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !res_valid);

    // R8: a branch that is not taken falls through to the next pointer
    a_r8_fall_through: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !branch_taken) |-> next_pc == $past(next_ptr));

    // R11: the flag holds until a clear pulse
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (fly_status && !fly_clear) |=> fly_status);

    // R11: a taken instruction with the fly bit raises the flag
    a_r11_set: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_fly_irq) |=> (!branch_taken || fly_status));
endmodule

bind script_branch_eval sbc_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_strobe    (req_strobe),
    .lat_phase     (lat_phase),
    .instr_valid   (instr_valid),
    .instr_fly_irq (instr_fly_irq),
    .next_ptr      (next_ptr),
    .fly_clear     (fly_clear),
    .res_valid     (res_valid),
    .branch_taken  (branch_taken),
    .next_pc       (next_pc),
    .fly_status    (fly_status)
);

// File: tb/script_branch_eval_bench.sv
module script_branch_eval_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_strobe = 0, ph_msg = 0, ph_cd = 0, ph_io = 0, target_mode = 0;
    logic        instr_valid = 0;
    logic [1:0]  instr_kind = 0;
    logic        instr_carry_test = 0, instr_phase_en = 0, instr_data_en = 0;
    logic        instr_if_true = 0, instr_fly_irq = 0, instr_rel = 0;
    logic [2:0]  instr_phase = 0;
    logic [7:0]  instr_data = 0, bus_data = 0;
    logic [31:0] instr_target = 0, next_ptr = 0;
    logic        alu_carry = 0, fly_clear = 0;
    logic        res_valid, branch_taken, fly_status;
    logic [31:0] next_pc;

    int vectors = 0;
    int misses  = 0;
    logic [2:0] model_phase = 3'b000;

    typedef struct {
        logic        taken;
        logic [31:0] pc;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    script_branch_eval u_script_branch_eval (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb.size() == 0) begin
                check("R8 unexpected result", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " taken"}, {31'd0, branch_taken}, {31'd0, e.taken});
                check({e.tag, " pc"}, next_pc, e.pc);
            end
        end
    end

    function automatic logic model_taken(logic ct, logic pe, logic de, logic it,
                                         logic [2:0] ph, logic [7:0] dat,
                                         logic [7:0] bus, logic carry);
        logic pact, any, m;
        pact = pe && !target_mode;
        any  = ct || pact || de;
        if (ct) m = carry;
        else    m = (!pact || (model_phase == ph)) && (!de || (bus == dat));
        return !any || (m == it);
    endfunction

    task automatic issue(input string tag, input logic [1:0] kind, input logic ct,
                         input logic pe, input logic de, input logic it,
                         input logic fi, input logic rel, input logic [2:0] ph,
                         input logic [7:0] dat, input logic [31:0] tgt,
                         input logic [7:0] bus, input logic carry,
                         input logic [31:0] ptr);
        exp_t e;
        logic [31:0] dest;
        @(negedge clk);
        instr_kind = kind; instr_carry_test = ct; instr_phase_en = pe;
        instr_data_en = de; instr_if_true = it; instr_fly_irq = fi;
        instr_rel = rel; instr_phase = ph; instr_data = dat;
        instr_target = tgt; bus_data = bus; alu_carry = carry; next_ptr = ptr;
        instr_valid = 1'b1;
        e.taken = model_taken(ct, pe, de, it, ph, dat, bus, carry);
        if (rel && kind[1] == 1'b0) dest = ptr + {{8{tgt[23]}}, tgt[23:0]};
        else                        dest = tgt;
        e.pc  = e.taken ? dest : ptr;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic phase_req(input logic [2:0] p);
        @(negedge clk);
        {ph_msg, ph_cd, ph_io} = p;
        req_strobe = 1'b1;
        model_phase = p;
        @(negedge clk);
        req_strobe = 1'b0;
    endtask

    initial begin
        #400000;
        misses++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 res_valid", {31'd0, res_valid}, 32'd0);
        check("R1 fly_status", {31'd0, fly_status}, 32'd0);
        check("R1 next_pc", next_pc, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 taken after reset", {31'd0, branch_taken}, 32'd0);
        // R1: captured phase is 000 after reset
        issue("R1 reset phase", 2'b00, 0,1,0,1, 0,0, 3'b000, 8'h00, 32'h0000_0100, 8'h00, 0, 32'h40);

        // R6: unconditional jump with either polarity
        issue("R6 uncond it1", 2'b00, 0,0,0,1, 0,0, 3'b000, 8'h00, 32'h1234_5678, 8'h00, 0, 32'h80);
        issue("R6 uncond it0", 2'b00, 0,0,0,0, 0,0, 3'b000, 8'h00, 32'h0000_0ABC, 8'h00, 0, 32'h84);

        // R2 R3: capture message-in, compare
        phase_req(3'b111);
        issue("R3 phase match", 2'b00, 0,1,0,1, 0,0, 3'b111, 8'h00, 32'h200, 8'h00, 0, 32'h90);
        issue("R3 phase miss",  2'b00, 0,1,0,1, 0,0, 3'b010, 8'h00, 32'h200, 8'h00, 0, 32'h94);
        issue("R6 polarity false", 2'b00, 0,1,0,0, 0,0, 3'b010, 8'h00, 32'h300, 8'h00, 0, 32'h98);
        phase_req(3'b011);
        issue("R3 status match", 2'b01, 0,1,0,1, 0,0, 3'b011, 8'h00, 32'h400, 8'h00, 0, 32'h9C);

        // R2: strobe held high while lines change
        @(negedge clk);
        {ph_msg, ph_cd, ph_io} = 3'b001; req_strobe = 1'b1; model_phase = 3'b001;
        @(negedge clk);
        {ph_msg, ph_cd, ph_io} = 3'b110;
        issue("R2 hold first", 2'b00, 0,1,0,1, 0,0, 3'b001, 8'h00, 32'h500, 8'h00, 0, 32'hA0);
        issue("R2 ignore later", 2'b00, 0,1,0,1, 0,0, 3'b110, 8'h00, 32'h500, 8'h00, 0, 32'hA4);
        @(negedge clk); req_strobe = 1'b0;

        // R4: data compare and combined AND
        issue("R4 data match", 2'b00, 0,0,1,1, 0,0, 3'b000, 8'h5A, 32'h600, 8'h5A, 0, 32'hB0);
        issue("R4 data miss",  2'b00, 0,0,1,1, 0,0, 3'b000, 8'h5A, 32'h600, 8'hA5, 0, 32'hB4);
        issue("R4 both one miss", 2'b00, 0,1,1,1, 0,0, 3'b001, 8'h5A, 32'h600, 8'h00, 0, 32'hB8);
        issue("R4 both match", 2'b00, 0,1,1,1, 0,0, 3'b001, 8'h5A, 32'h640, 8'h5A, 0, 32'hBC);

        // R5: carry test overrides compares
        issue("R5 carry set",   2'b00, 1,0,0,1, 0,0, 3'b000, 8'h00, 32'h700, 8'h00, 1, 32'hC0);
        issue("R5 carry clear", 2'b00, 1,0,0,1, 0,0, 3'b000, 8'h00, 32'h700, 8'h00, 0, 32'hC4);
        issue("R5 carry over phase", 2'b00, 1,1,1,1, 0,0, 3'b111, 8'h11, 32'h740, 8'h22, 1, 32'hC8);

        // R7: target mode ignores the phase enable
        target_mode = 1'b1;
        issue("R7 phase ignored", 2'b00, 0,1,0,0, 0,0, 3'b111, 8'h00, 32'h800, 8'h00, 0, 32'hD0);
        issue("R7 data still used", 2'b00, 0,1,1,1, 0,0, 3'b111, 8'h33, 32'h840, 8'h33, 0, 32'hD4);
        target_mode = 1'b0;

        // R9: relative targets
        issue("R9 rel negative", 2'b00, 0,0,0,1, 0,1, 3'b000, 8'h00, 32'h00FF_FFF0, 8'h00, 0, 32'h0000_1000);
        issue("R9 rel positive", 2'b01, 0,0,0,1, 0,1, 3'b000, 8'h00, 32'h0000_0020, 8'h00, 0, 32'h0000_1000);
        issue("R9 rel wrap",     2'b00, 0,0,0,1, 0,1, 3'b000, 8'h00, 32'h0000_0010, 8'h00, 0, 32'hFFFF_FFF8);
        check("R9 wrap model", 32'hFFFF_FFF8 + 32'h10, 32'h0000_0008);
        // R10: return and interrupt stay absolute
        issue("R10 return abs", 2'b10, 0,0,0,1, 0,1, 3'b000, 8'h00, 32'h00FF_FFF0, 8'h00, 0, 32'h2000);
        issue("R10 intr abs",   2'b11, 0,0,0,1, 0,1, 3'b000, 8'h00, 32'h0000_0044, 8'h00, 0, 32'h2000);

        // R11: fly interrupt
        check("R11 initially clear", {31'd0, fly_status}, 32'd0);
        issue("R11 not taken", 2'b00, 1,0,0,1, 1,0, 3'b000, 8'h00, 32'h900, 8'h00, 0, 32'hE0);
        check("R11 no set when not taken", {31'd0, fly_status}, 32'd0);
        issue("R11 taken", 2'b00, 0,0,0,1, 1,0, 3'b000, 8'h00, 32'h900, 8'h00, 0, 32'hE4);
        check("R11 set", {31'd0, fly_status}, 32'd1);
        repeat (4) @(negedge clk);
        check("R11 sticky", {31'd0, fly_status}, 32'd1);
        @(negedge clk); fly_clear = 1'b1;
        @(negedge clk); fly_clear = 1'b0;
        check("R11 cleared", {31'd0, fly_status}, 32'd0);
        fly_clear = 1'b1;
        issue("R11 set beats clear", 2'b00, 0,0,0,1, 1,0, 3'b000, 8'h00, 32'h940, 8'h00, 0, 32'hE8);
        fly_clear = 1'b0;
        check("R11 set wins", {31'd0, fly_status}, 32'd1);

        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", sb.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule